// File: doc/BRIEF.md
# Reset Cause Arbiter and Recorder

This block decides which reset, if any, is taken when several reset requests arrive, drives the chip-wide and external reset lines for it, and keeps a small status register that names the cause of the most recent reset. It takes four sources. The first is an asynchronous power-on reset. The second is a loss-of-reference indication from the clock synthesizer, which only counts when both a reset-enable control bit and the VCO-enabled flag are high. The third is a watchdog reset request. The fourth is a software reset request raised when the processor executes its reset instruction.

Power-on, loss-of-clock and watchdog resets are full resets: the global reset and the external reset line are both asserted. The software reset is partial. It raises the external reset line and emits a one-cycle soft-reset strobe that peripherals use to clear their ordinary registers. The global reset stays low, so configuration registers, processor state and the reset-vector fetch are not disturbed. The status register is read over a simple select/write bus and cannot be written.

Top module: `rstCauseTop`

## Requirements
- R1: While `porN` is low, the status reads 0x08 (bit 3 = power-on), and `globalRst` and `extRstOut` are high. After `porN` rises, `extRstOut` and `globalRst` stay high for 15 more falling-edge samples, then drop.
- R2: A loss of reference with `rstEnable` and `vcoOn` both high sets the status to 0x04 (bit 2 = loss-of-clock) and asserts `globalRst` and `extRstOut`, with `softRst` low.
- R3: A loss of reference while `rstEnable` or `vcoOn` is low has no effect: `extRstOut` stays low and the status is unchanged.
- R4: A watchdog request sets the status to 0x02 (bit 1 = watchdog) and asserts `globalRst` and `extRstOut`.
- R5: A software request sets the status to 0x01 (bit 0 = software) and asserts `extRstOut`. It pulses `softRst` for exactly one cycle and leaves `globalRst` low.
- R6: After any reset, exactly one status bit is set, and the bit of any earlier cause is cleared.
- R7: When requests coincide in one cycle, the priority is power-on, then loss-of-clock, then watchdog, then software. Only the winner is recorded and acted on.
- R8: A bus access with `busWrite` high leaves the status unchanged and returns 0. A read (`busSel` high, `busWrite` low) returns the status in bits 3:0 with the upper bits zero. With `busSel` low, `busRdata` is 0.
- R9: A synchronous reset holds `extRstOut` high for exactly 16 cycles after the edge that samples the request. Requests that arrive while `extRstOut` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| lossOfRef | input | 1 | Clock synthesizer lost its frequency reference |
| rstEnable | input | 1 | Control bit allowing a loss of reference to reset |
| vcoOn | input | 1 | VCO is enabled |
| wdRstReq | input | 1 | Watchdog reset request |
| swRstReq | input | 1 | Reset-instruction request |
| busSel | input | 1 | Register bus select |
| busWrite | input | 1 | Register bus write (ignored) |
| busRdata | output | 8 | Status read data |
| globalRst | output | 1 | Full chip reset |
| extRstOut | output | 1 | Stretched external reset |
| softRst | output | 1 | One-cycle peripheral soft-reset strobe |

## Verification
Each source is applied alone, so the recorded cause and the choice between full and partial reset can be tied to a single input. A loss of reference is applied with each gate bit low in turn, which shows whether both gates are needed. Coinciding requests (all three sources together, then watchdog with software) separate the priority order from the order of arrival. A request made in the middle of a stretch shows whether a reset in progress can be restarted or relabelled.

// File: rtl/rstCausePkg.sv
package rstCausePkg;
  localparam int CAUSE_N = 4;
  localparam int IDX_SW  = 0;
  localparam int IDX_WD  = 1;
  localparam int IDX_LOC = 2;
  localparam int IDX_POR = 3;

  typedef struct packed {
    logic setLoc;
    logic setWd;
    logic setSw;
  } rstStrobe_t;
endpackage

// File: rtl/rstArbCtl.sv
module rstArbCtl
  import rstCausePkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       lossOfRef,
  input  logic       rstEnable,
  input  logic       vcoOn,
  input  logic       wdRstReq,
  input  logic       swRstReq,
  output rstStrobe_t strobes,
  output logic       extRstOut,
  output logic       globalRst
);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [CNT_W-1:0] stretchCnt;
  logic             fullQ;
  logic             busy;
  logic             locOk;
  logic             anyFire;

  assign busy  = (stretchCnt != '0);
  assign locOk = lossOfRef & rstEnable & vcoOn;

  // fixed priority among synchronous sources; nothing accepted while busy
  always_comb begin
    strobes = '0;
    if (!busy) begin
      if (locOk)         strobes.setLoc = 1'b1;
      else if (wdRstReq) strobes.setWd  = 1'b1;
      else if (swRstReq) strobes.setSw  = 1'b1;
    end
  end

  assign anyFire = |strobes;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stretchCnt <= CNT_W'(STRETCH);
      fullQ      <= 1'b1;
    end else if (anyFire) begin
      stretchCnt <= CNT_W'(STRETCH);
      fullQ      <= strobes.setLoc | strobes.setWd;
    end else if (busy) begin
      stretchCnt <= stretchCnt - 1'b1;
    end
  end

  assign extRstOut = busy;
  assign globalRst = busy & fullQ;

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(strobes));

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(extRstOut) |=> extRstOut);
endmodule

// File: rtl/rstStatusPath.sv
module rstStatusPath
  import rstCausePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  rstStrobe_t        strobes,
  input  logic              busSel,
  input  logic              busWrite,
  output logic [DATA_W-1:0] busRdata,
  output logic              softRst
);
  logic [CAUSE_N-1:0] statusQ;
  logic [CAUSE_N-1:0] statusNext;
  logic               softQ;

  always_comb begin
    statusNext = statusQ;
    if (strobes.setLoc)     statusNext = CAUSE_N'(1) << IDX_LOC;
    else if (strobes.setWd) statusNext = CAUSE_N'(1) << IDX_WD;
    else if (strobes.setSw) statusNext = CAUSE_N'(1) << IDX_SW;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      statusQ <= CAUSE_N'(1) << IDX_POR;
      softQ   <= 1'b0;
    end else begin
      statusQ <= statusNext;
      softQ   <= strobes.setSw;
    end
  end

  assign softRst  = softQ;
  assign busRdata = (busSel && !busWrite) ? DATA_W'(statusQ) : '0;

  // R6
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $countones(statusQ) == 1);

  // R8
  write_ignore_chk: assert property (@(posedge clk) disable iff (!porN)
    (busSel && busWrite && strobes == '0) |=> $stable(statusQ));

  // R5
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!porN)
    softQ |=> !softQ);
endmodule

// File: rtl/rstCauseTop.sv
module rstCauseTop
  import rstCausePkg::*;
#(
  parameter int STRETCH = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              lossOfRef,
  input  logic              rstEnable,
  input  logic              vcoOn,
  input  logic              wdRstReq,
  input  logic              swRstReq,
  input  logic              busSel,
  input  logic              busWrite,
  output logic [DATA_W-1:0] busRdata,
  output logic              globalRst,
  output logic              extRstOut,
  output logic              softRst
);
  rstStrobe_t strobes;

  rstArbCtl #(.STRETCH(STRETCH)) uCtl (
    .clk(clk), .porN(porN), .lossOfRef(lossOfRef), .rstEnable(rstEnable),
    .vcoOn(vcoOn), .wdRstReq(wdRstReq), .swRstReq(swRstReq),
    .strobes(strobes), .extRstOut(extRstOut), .globalRst(globalRst)
  );

  rstStatusPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .porN(porN), .strobes(strobes), .busSel(busSel),
    .busWrite(busWrite), .busRdata(busRdata), .softRst(softRst)
  );

  // R3
  loc_gate_chk: assert property (@(posedge clk) disable iff (!porN)
    (lossOfRef && !(rstEnable && vcoOn) && !wdRstReq && !swRstReq && !extRstOut)
      |=> !extRstOut);

  // R5
  soft_partial_chk: assert property (@(posedge clk) disable iff (!porN)
    softRst |-> (extRstOut && !globalRst));
endmodule

// File: tb/sim_rstCauseTop.sv
module sim_rstCauseTop;
  logic clk = 1'b0;
  logic porN = 1'b0;
  logic lossOfRef = 0, rstEnable = 0, vcoOn = 0, wdRstReq = 0, swRstReq = 0;
  logic busSel = 0, busWrite = 0;
  logic [7:0] busRdata;
  logic globalRst, extRstOut, softRst;
  int nChecks = 0, nFails = 0;

  always #10ns clk = ~clk;

  rstCauseTop u0 (
    .clk(clk), .porN(porN), .lossOfRef(lossOfRef), .rstEnable(rstEnable),
    .vcoOn(vcoOn), .wdRstReq(wdRstReq), .swRstReq(swRstReq),
    .busSel(busSel), .busWrite(busWrite), .busRdata(busRdata),
    .globalRst(globalRst), .extRstOut(extRstOut), .softRst(softRst)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readStatus(output int val);
    busSel = 1; busWrite = 0; #1;
    val = busRdata;
    busSel = 0; #1;
  endtask

  // count falling-edge samples with extRstOut high, starting now
  task automatic measureStretch(output int n);
    n = 0;
    while (extRstOut && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fire(logic l, logic w, logic s);
    @(negedge clk);
    lossOfRef = l; wdRstReq = w; swRstReq = s;
    @(negedge clk);
    lossOfRef = 0; wdRstReq = 0; swRstReq = 0;
  endtask

  task automatic tPowerOn();
    int v, n;
    porN = 0; #35ns;
    readStatus(v);
    check("R1 status", v, 8);
    check("R1 globalRst", globalRst, 1);
    check("R1 extRstOut", extRstOut, 1);
    @(negedge clk); porN = 1;
    @(negedge clk);
    measureStretch(n);
    check("R1 stretch", n, 15);
    check("R1 globalRst off", globalRst, 0);
  endtask

  task automatic tLoc();
    int v, n;
    rstEnable = 1; vcoOn = 1;
    fire(1, 0, 0);
    readStatus(v);
    check("R2 status", v, 4);
    check("R2 globalRst", globalRst, 1);
    check("R2 softRst", softRst, 0);
    measureStretch(n);
    check("R9 stretch loc", n, 16);
  endtask

  task automatic tLocGated();
    int v;
    rstEnable = 0; vcoOn = 1;
    fire(1, 0, 0);
    check("R3 enable low", extRstOut, 0);
    rstEnable = 1; vcoOn = 0;
    fire(1, 0, 0);
    check("R3 vco low", extRstOut, 0);
    readStatus(v);
    check("R3 status kept", v, 4);
    vcoOn = 1;
  endtask

  task automatic tWd();
    int v, n;
    fire(0, 1, 0);
    readStatus(v);
    check("R4 status", v, 2);
    check("R6 loc bit cleared", v & 4, 0);
    check("R4 globalRst", globalRst, 1);
    measureStretch(n);
  endtask

  task automatic tSw();
    int v, n;
    fire(0, 0, 1);
    readStatus(v);
    check("R5 status", v, 1);
    check("R6 one bit", $countones(v[3:0]), 1);
    check("R5 softRst", softRst, 1);
    check("R5 globalRst low", globalRst, 0);
    check("R5 extRstOut", extRstOut, 1);
    @(negedge clk);
    check("R5 softRst one cycle", softRst, 0);
    measureStretch(n);
    check("R9 stretch sw", n, 15);
  endtask

  task automatic tPrio();
    int v, n;
    fire(1, 1, 1);
    readStatus(v);
    check("R7 all three", v, 4);
    check("R7 no soft", softRst, 0);
    measureStretch(n);
    fire(0, 1, 1);
    readStatus(v);
    check("R7 wd over sw", v, 2);
    check("R7 no soft wd", softRst, 0);
    measureStretch(n);
  endtask

  task automatic tBusy();
    int v, n;
    fire(0, 1, 0);
    repeat (4) @(negedge clk);
    swRstReq = 1;
    @(negedge clk);
    swRstReq = 0;
    readStatus(v);
    check("R9 busy status", v, 2);
    check("R9 busy soft", softRst, 0);
    measureStretch(n);
    check("R9 busy stretch", n, 11);
  endtask

  task automatic tWrite();
    int v;
    @(negedge clk);
    busSel = 1; busWrite = 1; #1;
    check("R8 write rdata", busRdata, 0);
    @(negedge clk);
    busSel = 0; busWrite = 0; #1;
    check("R8 unselected", busRdata, 0);
    readStatus(v);
    check("R8 status kept", v, 2);
  endtask

  initial begin
    tPowerOn();
    tLoc();
    tLocGated();
    tWd();
    tSw();
    tPrio();
    tBusy();
    tWrite();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule